// File: doc/BRIEF.md
# Prescaled Timebase with Selectable Trigger Output

This block is a general-purpose timebase. A prescaler divides the clock, and each prescaler terminal count steps a counter up or down between zero and a reload limit. Every wrap of the counter raises a one-cycle update event. A software strobe can also force an update event. An update event commits the buffered prescaler and reload values and restarts the count. The period between update events is therefore (prescale + 1) x (reload + 1) clock cycles.

A three-bit trigger-source field picks what drives the single trigger output. The choices are a pulse on the software restart, the live counter-enable level, a pulse on each update event, a pulse when the count reaches a compare value, or one of four external compare-reference levels. Other blocks, for example a converter that must sample at a fixed rate, listen to this output.

The register port is a single-cycle write with a combinational read. Register addresses: 0 control (bit0 run, bit1 count down, bit2 reload buffering), 1 trigger source, 2 prescale, 3 reload, 4 count, 5 force (write bit0 = 1 to force an update event; reads 0), 6 compare value.

Top module: `trig_timebase`

## Requirements
- R1: With the counter enabled, update events repeat every (P + 1) x (A + 1) cycles, where P is the committed prescale and A the committed reload value.
- R2: Counting up, the count goes from A to 0 on a step and raises `updateEvt`. Counting down (control bit1 = 1), it goes from 0 to A on a step and raises `updateEvt`.
- R3: With control bit2 = 0, a reload write takes effect on the next edge. With bit2 = 1, the written value is held and committed only at the next update event.
- R4: Writing 1 to bit0 of address 5 forces an update event on that edge. It commits the prescale and reload values, clears the prescaler, sets the count to 0 (up) or to the new reload value (down), and pulses `updateEvt` for one cycle.
- R5: The count advances only while control bit0 = 1 and `cntEnIn` = 1; otherwise it holds.
- R6: A prescale write never changes the running division; it is committed only by an update event.
- R7: Trigger source 0 pulses `trgo` for one cycle on a forced update. Source 1 drives `trgo` with the counter-enable level, one cycle later.
- R8: Source 2 makes `trgo` equal to the `updateEvt` pulse. Source 3 pulses `trgo` for one cycle when a counter step lands on the compare value.
- R9: Sources 4 to 7 drive `trgo` with `cmpRef[0]` to `cmpRef[3]`, one cycle later.
- R10: After reset every register, the count, `trgo` and `updateEvt` are 0. Addresses 0, 1, 2, 3 and 6 read back the last written value. Address 4 reads the live count, and a count write loads the count on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | DATA_W | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | DATA_W | Read data, combinational |
| cntEnIn | input | 1 | External counting enable |
| cmpRef | input | 4 | Compare-reference levels for sources 4 to 7 |
| updateEvt | output | 1 | One-cycle update event pulse |
| trgo | output | 1 | Trigger output |

## Verification
On every cycle the assertions check several invariants. The prescaler count never exceeds its committed limit, and the count holds while counting is disabled. A buffered reload limit stays put between update events. A forced update clears the prescaler and pulses the event, an up-count wrap lands on zero with an event, and in update mode every event appears on the trigger. Other behaviours need the bench's scenarios. These include the exact event period across prescale and reload combinations, the deferred commit of a prescale write, down-count wrapping, the compare pulse, and the mapping of each trigger source to its reference input.

// File: rtl/ttb_pkg.sv
package ttb_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_MODE  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_PSC   = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_RLD   = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_CNT   = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_FORCE = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_CMP   = 3'd6;

  typedef enum logic [2:0] {
    MM_RESTART = 3'd0,
    MM_ENABLE  = 3'd1,
    MM_UPDATE  = 3'd2,
    MM_CMPHIT  = 3'd3,
    MM_REF0    = 3'd4,
    MM_REF1    = 3'd5,
    MM_REF2    = 3'd6,
    MM_REF3    = 3'd7
  } trigSrc_t;

  typedef struct packed {
    logic ugStb;
    logic cntWr;
    logic arrWr;
  } ttbStrobe_t;
endpackage

// File: rtl/ttb_ctrl.sv
module ttb_ctrl
  import ttb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PSC_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] curCount,
  output ttbStrobe_t        stb,
  output logic              runQ,
  output logic              downQ,
  output logic              preloadQ,
  output trigSrc_t          modeQ,
  output logic [PSC_W-1:0]  pscPreQ,
  output logic [DATA_W-1:0] arrPreQ,
  output logic [DATA_W-1:0] cmpQ
);
  localparam int CTRL_BITS = 3;

  always_comb begin
    stb.ugStb = wrEn && (wrAddr == ADR_FORCE) && wrData[0];
    stb.cntWr = wrEn && (wrAddr == ADR_CNT);
    stb.arrWr = wrEn && (wrAddr == ADR_RLD);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ     <= 1'b0;
      downQ    <= 1'b0;
      preloadQ <= 1'b0;
      modeQ    <= MM_RESTART;
      pscPreQ  <= '0;
      arrPreQ  <= '0;
      cmpQ     <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADR_CTRL: begin
          runQ     <= wrData[0];
          downQ    <= wrData[1];
          preloadQ <= wrData[2];
        end
        ADR_MODE: modeQ   <= trigSrc_t'(wrData[2:0]);
        ADR_PSC:  pscPreQ <= wrData[PSC_W-1:0];
        ADR_RLD:  arrPreQ <= wrData;
        ADR_CMP:  cmpQ    <= wrData;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADR_CTRL: rdData = DATA_W'({preloadQ, downQ, runQ});
      ADR_MODE: rdData = DATA_W'(modeQ);
      ADR_PSC:  rdData = DATA_W'(pscPreQ);
      ADR_RLD:  rdData = arrPreQ;
      ADR_CNT:  rdData = curCount;
      ADR_CMP:  rdData = cmpQ;
      default:  rdData = '0;
    endcase
  end

  // R4: a force strobe never coincides with a data-register write
  ug_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ugStb |-> !(stb.cntWr || stb.arrWr));

  logic unusedCtrl;
  assign unusedCtrl = ^{CTRL_BITS};
endmodule

// File: rtl/ttb_datapath.sv
module ttb_datapath
  import ttb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PSC_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ttbStrobe_t        stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cntEn,
  input  logic              downQ,
  input  logic              preloadQ,
  input  trigSrc_t          modeQ,
  input  logic [PSC_W-1:0]  pscPreQ,
  input  logic [DATA_W-1:0] arrPreQ,
  input  logic [DATA_W-1:0] cmpQ,
  input  logic [3:0]        cmpRef,
  output logic [DATA_W-1:0] count,
  output logic              updateEvt,
  output logic              trgo
);
  logic [PSC_W-1:0]  pscCnt, pscAct;
  logic [DATA_W-1:0] arrAct, nextCnt;
  logic tick, wrapHit, updEvt, cmpHit, trgoNext;

  always_comb begin
    tick    = cntEn && (pscCnt == pscAct);
    wrapHit = tick && (downQ ? (count == '0) : (count == arrAct));
    updEvt  = stb.ugStb || wrapHit;
    if (downQ) nextCnt = (count == '0) ? arrAct : count - 1'b1;
    else       nextCnt = (count == arrAct) ? '0 : count + 1'b1;
    cmpHit  = tick && !stb.cntWr && !stb.ugStb && (nextCnt == cmpQ);
  end

  // Prescaler: committed limit changes only at update events
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pscCnt <= '0;
      pscAct <= '0;
    end else begin
      if (updEvt) pscAct <= pscPreQ;
      if (stb.ugStb)  pscCnt <= '0;
      else if (cntEn) pscCnt <= tick ? '0 : pscCnt + 1'b1;
    end
  end

  // Reload limit: direct write when unbuffered, else commit on update
  always_ff @(posedge clk) begin
    if (!rstN)                         arrAct <= '0;
    else if (stb.arrWr && !preloadQ)   arrAct <= wrData;
    else if (updEvt)                   arrAct <= arrPreQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          count <= '0;
    else if (stb.ugStb) count <= downQ ? arrPreQ : '0;
    else if (stb.cntWr) count <= wrData;
    else if (tick)      count <= nextCnt;
  end

  always_comb begin
    case (modeQ)
      MM_RESTART: trgoNext = stb.ugStb;
      MM_ENABLE:  trgoNext = cntEn;
      MM_UPDATE:  trgoNext = updEvt;
      MM_CMPHIT:  trgoNext = cmpHit;
      default:    trgoNext = cmpRef[modeQ[1:0]];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      updateEvt <= 1'b0;
      trgo      <= 1'b0;
    end else begin
      updateEvt <= updEvt;
      trgo      <= trgoNext;
    end
  end

  // R1
  psc_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    pscCnt <= pscAct);

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cntEn && !stb.ugStb && !stb.cntWr) |=> $stable(count));

  // R3
  preload_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (preloadQ && !updEvt) |=> $stable(arrAct));

  // R4
  ug_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ugStb |=> (pscCnt == '0) && updateEvt);

  // R2
  up_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !downQ && (count == arrAct) && !stb.cntWr && !stb.ugStb)
      |=> (count == '0) && updateEvt);

  // R8
  upd_trgo_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MM_UPDATE && updEvt) |=> trgo);
endmodule

// File: rtl/trig_timebase.sv
module trig_timebase
  import ttb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PSC_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [2:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              cntEnIn,
  input  logic [3:0]        cmpRef,
  output logic              updateEvt,
  output logic              trgo
);
  ttbStrobe_t        stb;
  logic              runQ, downQ, preloadQ;
  trigSrc_t          modeQ;
  logic [PSC_W-1:0]  pscPreQ;
  logic [DATA_W-1:0] arrPreQ, cmpQ, count;
  logic              cntEn;

  assign cntEn = runQ && cntEnIn;

  ttb_ctrl #(.DATA_W(DATA_W), .PSC_W(PSC_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .curCount(count), .stb(stb),
    .runQ(runQ), .downQ(downQ), .preloadQ(preloadQ), .modeQ(modeQ),
    .pscPreQ(pscPreQ), .arrPreQ(arrPreQ), .cmpQ(cmpQ)
  );

  ttb_datapath #(.DATA_W(DATA_W), .PSC_W(PSC_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .cntEn(cntEn),
    .downQ(downQ), .preloadQ(preloadQ), .modeQ(modeQ), .pscPreQ(pscPreQ),
    .arrPreQ(arrPreQ), .cmpQ(cmpQ), .cmpRef(cmpRef), .count(count),
    .updateEvt(updateEvt), .trgo(trgo)
  );
endmodule

// File: tb/tb_trig_timebase.sv
module tb_trig_timebase;
  localparam int DW = 16;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0, rdAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic cntEnIn = 1'b1;
  logic [3:0] cmpRef = '0;
  logic updateEvt, trgo;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  trig_timebase #(.DATA_W(DW), .PSC_W(DW)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .cntEnIn(cntEnIn), .cmpRef(cmpRef),
    .updateEvt(updateEvt), .trgo(trgo)
  );

  // {prescale, reload, down, expected period}
  localparam int VEC [6][4] = '{
    '{0, 0, 0, 1}, '{0, 4, 0, 5}, '{2, 3, 0, 12},
    '{1, 6, 1, 14}, '{3, 0, 1, 4}, '{4, 2, 1, 15}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = DW'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic int cnt();
    return int'(dut.rdData);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    rdAddr = 3'd0; #1 chk("R10 ctrl reset", int'(rdData), 0);
    rdAddr = 3'd4; #1 chk("R10 count reset", int'(rdData), 0);
    chk("R10 trgo reset", int'(trgo), 0);
    chk("R10 updateEvt reset", int'(updateEvt), 0);

    // R10 readback
    wr(3'd6, 16'h1234); rdAddr = 3'd6; #1 chk("R10 cmp readback", int'(rdData), 'h1234);
    wr(3'd1, 2); rdAddr = 3'd1; #1 chk("R10 mode readback", int'(rdData), 2);
    wr(3'd4, 77); rdAddr = 3'd4; #1 chk("R10 count write", int'(rdData), 77);

    // R1 / R2 vector table, trigger source 2 (R8)
    for (int v = 0; v < 6; v++) begin
      int n;
      wr(3'd0, VEC[v][2] * 2);
      wr(3'd2, VEC[v][0]);
      wr(3'd3, VEC[v][1]);
      wr(3'd0, 1 + VEC[v][2] * 2);
      wr(3'd5, 1);
      chk("R4 forced update pulse", int'(updateEvt), 1);
      chk("R8 update trgo", int'(trgo), 1);
      n = 0;
      do begin @(negedge clk); n++; end while (!updateEvt && n < 200);
      chk("R1 update period", n, VEC[v][3]);
    end

    // R3 buffered reload
    wr(3'd0, 0); wr(3'd2, 0); wr(3'd5, 1);
    wr(3'd0, 4); wr(3'd3, 9); wr(3'd5, 1);
    wr(3'd3, 3); wr(3'd4, 5);
    rdAddr = 3'd3; #1 chk("R3 reload readback", int'(rdData), 3);
    rdAddr = 3'd4;
    wr(3'd0, 5);
    step(4); chk("R3 buffered limit still old", cnt(), 9);
    step(1); chk("R2 up wrap to 0", cnt(), 0); chk("R2 up wrap event", int'(updateEvt), 1);
    step(3); chk("R3 committed limit", cnt(), 3);
    step(1); chk("R3 wrap at new limit", cnt(), 0); chk("R3 event", int'(updateEvt), 1);
    // R3 unbuffered
    wr(3'd0, 0); wr(3'd4, 0); wr(3'd3, 2); wr(3'd0, 1);
    step(2); chk("R3 direct limit", cnt(), 2);
    step(1); chk("R3 direct wrap", cnt(), 0); chk("R3 direct event", int'(updateEvt), 1);

    // R6 deferred prescale
    wr(3'd0, 0); wr(3'd3, 20); wr(3'd2, 3); wr(3'd4, 0); wr(3'd0, 1);
    step(3); chk("R6 prescale not yet committed", cnt(), 3);
    wr(3'd5, 1); chk("R4 restart count", cnt(), 0);
    step(3); chk("R6 divided hold", cnt(), 0);
    step(1); chk("R6 divided step", cnt(), 1);

    // R5 enable gating
    wr(3'd0, 0); wr(3'd2, 0); wr(3'd5, 1); wr(3'd4, 4);
    step(5); chk("R5 run bit clear holds", cnt(), 4);
    cntEnIn = 1'b0; wr(3'd0, 1);
    step(5); chk("R5 input low holds", cnt(), 4);
    cntEnIn = 1'b1;
    step(2); chk("R5 counting resumes", cnt(), 6);

    // R8 compare pulse
    wr(3'd0, 0); wr(3'd1, 3); wr(3'd6, 5); wr(3'd3, 9); wr(3'd4, 0); wr(3'd0, 1);
    step(4); chk("R8 no early compare", int'(trgo), 0);
    step(1); chk("R8 compare count", cnt(), 5); chk("R8 compare pulse", int'(trgo), 1);
    step(1); chk("R8 compare pulse ends", int'(trgo), 0);

    // R7 restart and enable sources
    wr(3'd0, 0); wr(3'd1, 0);
    wr(3'd5, 1); chk("R7 restart pulse", int'(trgo), 1);
    step(1); chk("R7 restart pulse ends", int'(trgo), 0);
    wr(3'd1, 1); wr(3'd0, 1);
    chk("R7 enable lag", int'(trgo), 0);
    step(1); chk("R7 enable level", int'(trgo), 1);
    cntEnIn = 1'b0;
    step(1); chk("R7 enable drops", int'(trgo), 0);
    cntEnIn = 1'b1;

    // R9 reference sources
    wr(3'd0, 0);
    for (int i = 0; i < 4; i++) begin
      wr(3'd1, 4 + i);
      cmpRef = 4'(1 << i);
      step(1); chk("R9 reference high", int'(trgo), 1);
      cmpRef = ~4'(1 << i);
      step(1); chk("R9 reference low", int'(trgo), 0);
    end
    cmpRef = '0;

    // R2 down counting, R4 down restart
    wr(3'd1, 2); wr(3'd0, 2); wr(3'd3, 3); wr(3'd4, 1); wr(3'd0, 3);
    step(1); chk("R2 down step", cnt(), 0); chk("R2 no event at 0", int'(updateEvt), 0);
    step(1); chk("R2 down wrap", cnt(), 3); chk("R2 down event", int'(updateEvt), 1);
    wr(3'd0, 2); wr(3'd3, 7); wr(3'd5, 1);
    chk("R4 down restart loads reload", cnt(), 7);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule